// File: doc/BRIEF.md
# Multiplexed Byte-Wide Instruction Bus Controller

This controller connects a processor core to external program memory over a narrow multiplexed bus. Upper address bits go out on dedicated lines. The low sixteen address bits share one bus with the data. Read data returns on the low byte of that bus. A strobe tells an external latch when the address is valid.

Each request runs one instruction cycle of four clocks. An instruction fetch reads the even byte and then the odd byte, steered by a byte-select line, and returns them together as one 16-bit word. A byte table write copies its one data byte onto both halves of the shared bus. On a write, the byte-select line follows the pointer LSb, and a write strobe pulses in the middle of the cycle.

A sleep input forces every bus strobe inactive. It stops new cycles from starting and drops any cycle already running. Requests are level signals that the core holds until it sees an acknowledge. A new request is accepted in the last phase of the running cycle, so cycles can follow each other with no gap.

Top module: `ebc_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ce_no, oe_no and wr_no are high, ale_o is low, ad_oe_o is low and rdata_valid_o is low.
- R2: In phase 1 of a fetch cycle, ale_o is high and ad_oe_o is high. ad_o carries fetch address bits [15:0] with bit 0 forced to 0, and addr_hi_o carries bits [19:16]. ce_no is low in all four phases.
- R3: In phases 2 and 3 of a fetch, oe_no is low, ba0_o is 0 and ad_oe_o is low. In phase 4, oe_no stays low and ba0_o is 1.
- R4: The even byte is taken from ad_i[7:0] at the end of phase 3 and the odd byte at the end of phase 4. In the clock after phase 4, rdata_valid_o pulses for one clock and rdata_o holds {odd byte, even byte}.
- R5: In phase 1 of a write, ale_o is high and ad_o carries address bits [15:0]. In phases 2 to 4, ad_o carries the data byte in both halves with ad_oe_o high. ba0_o equals address bit 0 in all four phases. wr_no is low only in phase 3, and oe_no stays high.
- R6: fetch_ack_o or wr_ack_o is high in the clock where the request is taken. A request is taken when the controller is idle or in phase 4. If both requests are present, the fetch wins. A request held through an acknowledge starts its cycle on the next clock with no idle gap.
- R7: While sleep_i is high, no request is acknowledged. ce_no, oe_no and wr_no are high and ale_o is low. A cycle in progress is abandoned, and an abandoned fetch produces no rdata_valid_o pulse.
- R8: The controller never drives the shared bus while oe_no is low, and oe_no and wr_no are never low together.
- R9: With no request pending, all strobes stay inactive and ale_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one phase per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep: gates all bus activity |
| fetch_req_i | input | 1 | Instruction fetch request (level) |
| fetch_addr_i | input | 20 | Fetch byte address (bit 0 ignored) |
| fetch_ack_o | output | 1 | Fetch request taken this clock |
| wr_req_i | input | 1 | Table write request (level) |
| wr_addr_i | input | 20 | Table pointer |
| wr_data_i | input | 8 | Table latch byte |
| wr_ack_o | output | 1 | Write request taken this clock |
| rdata_o | output | 16 | Fetched instruction word |
| rdata_valid_o | output | 1 | rdata_o valid pulse |
| addr_hi_o | output | 4 | Upper address lines [19:16] |
| ad_o | output | 16 | Shared address/data bus output value |
| ad_oe_o | output | 1 | Shared bus drive enable |
| ad_i | input | 16 | Shared bus input (read data on [7:0]) |
| ale_o | output | 1 | Address latch strobe |
| ba0_o | output | 1 | Byte select (address LSb) |
| ce_no | output | 1 | Chip enable, active low |
| oe_no | output | 1 | Output enable, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
Suppose the phase counter slips or the latched operation is corrupted. Then the strobe pattern of the running cycle goes wrong within one clock: ale_o appears outside phase 1, oe_no and wr_no overlap, or ba0_o toggles at the wrong phase. A wrong even-byte capture only shows up at the following rdata_valid_o pulse, one clock after phase 4, as a bad low byte. A sleep gate or abort that fails shows ce_no low within the same clock sleep_i is high, or as a stray valid pulse two clocks later.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    PH_ADR = 2'd0,
    PH_LO1 = 2'd1,
    PH_LO2 = 2'd2,
    PH_HI  = 2'd3
  } ebc_ph_e;

  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_WRITE = 1'b1
  } ebc_op_e;
endpackage

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              fetch_ack_o,
  output logic              wr_ack_o,
  output logic              busy_o,
  output ebc_ph_e           ph_o,
  output ebc_op_e           op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o
);
  logic start;

  // slot opens when idle or in the final phase
  assign start       = (!busy_o || ph_o == PH_HI) && !sleep_i && (fetch_req_i || wr_req_i);
  assign fetch_ack_o = start && fetch_req_i;
  assign wr_ack_o    = start && !fetch_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      ph_o   <= PH_ADR;
      op_o   <= OP_FETCH;
      addr_o <= '0;
      data_o <= '0;
    end else if (sleep_i) begin
      busy_o <= 1'b0;
      ph_o   <= PH_ADR;
    end else if (start) begin
      busy_o <= 1'b1;
      ph_o   <= PH_ADR;
      op_o   <= fetch_req_i ? OP_FETCH : OP_WRITE;
      addr_o <= fetch_req_i ? fetch_addr_i : wr_addr_i;
      data_o <= wr_data_i;
    end else if (busy_o) begin
      if (ph_o == PH_HI) begin
        busy_o <= 1'b0;
        ph_o   <= PH_ADR;
      end else begin
        ph_o <= ebc_ph_e'(ph_o + 2'd1);
      end
    end
  end
endmodule

// File: rtl/ebc_drv.sv
module ebc_drv
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                     busy_i,
  input  logic                     sleep_i,
  input  ebc_ph_e                  ph_i,
  input  ebc_op_e                  op_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BYTE_W-1:0]        data_i,
  output logic [ADDR_W-2*BYTE_W-1:0] addr_hi_o,
  output logic [2*BYTE_W-1:0]      ad_o,
  output logic                     ad_oe_o,
  output logic                     ale_o,
  output logic                     ba0_o,
  output logic                     ce_no,
  output logic                     oe_no,
  output logic                     wr_no
);
  localparam int LO_W = 2 * BYTE_W;

  logic act;
  assign act = busy_i && !sleep_i;

  always_comb begin
    addr_hi_o = '0;
    ad_o      = '0;
    ad_oe_o   = 1'b0;
    ale_o     = 1'b0;
    ba0_o     = 1'b0;
    ce_no     = 1'b1;
    oe_no     = 1'b1;
    wr_no     = 1'b1;
    if (act) begin
      ce_no     = 1'b0;
      addr_hi_o = addr_i[ADDR_W-1:LO_W];
      if (op_i == OP_FETCH) begin
        unique case (ph_i)
          PH_ADR: begin
            ale_o   = 1'b1;
            ad_oe_o = 1'b1;
            ad_o    = {addr_i[LO_W-1:1], 1'b0};
          end
          PH_LO1, PH_LO2: oe_no = 1'b0;
          PH_HI: begin
            oe_no = 1'b0;
            ba0_o = 1'b1;
          end
        endcase
      end else begin
        ba0_o   = addr_i[0];
        ad_oe_o = 1'b1;
        if (ph_i == PH_ADR) begin
          ale_o = 1'b1;
          ad_o  = addr_i[LO_W-1:0];
        end else begin
          ad_o  = {data_i, data_i};
          wr_no = (ph_i != PH_LO2);
        end
      end
    end
  end
endmodule

// File: rtl/ebc_rdasm.sv
module ebc_rdasm
  import ebc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                sleep_i,
  input  ebc_ph_e             ph_i,
  input  ebc_op_e             op_i,
  input  logic [BYTE_W-1:0]   rd_byte_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                valid_o
);
  logic [BYTE_W-1:0] lo_q;
  logic              cap;

  assign cap = busy_i && !sleep_i && op_i == OP_FETCH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap && ph_i == PH_LO2) lo_q <= rd_byte_i;
      if (cap && ph_i == PH_HI) begin
        word_o  <= {rd_byte_i, lo_q};
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int LO_W  = 2 * BYTE_W,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ack_o,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              wr_ack_o,
  output logic [LO_W-1:0]   rdata_o,
  output logic              rdata_valid_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [LO_W-1:0]   ad_o,
  output logic              ad_oe_o,
  input  logic [LO_W-1:0]   ad_i,
  output logic              ale_o,
  output logic              ba0_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              wr_no
);
  logic              busy;
  ebc_ph_e           ph;
  ebc_op_e           op;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  ebc_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_i      (sleep_i),
    .fetch_req_i  (fetch_req_i),
    .fetch_addr_i (fetch_addr_i),
    .wr_req_i     (wr_req_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .fetch_ack_o  (fetch_ack_o),
    .wr_ack_o     (wr_ack_o),
    .busy_o       (busy),
    .ph_o         (ph),
    .op_o         (op),
    .addr_o       (addr_q),
    .data_o       (data_q)
  );

  ebc_drv #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_drv (
    .busy_i    (busy),
    .sleep_i   (sleep_i),
    .ph_i      (ph),
    .op_i      (op),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .ba0_o     (ba0_o),
    .ce_no     (ce_no),
    .oe_no     (oe_no),
    .wr_no     (wr_no)
  );

  ebc_rdasm #(.BYTE_W(BYTE_W)) u_rdasm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .sleep_i   (sleep_i),
    .ph_i      (ph),
    .op_i      (op),
    .rd_byte_i (ad_i[BYTE_W-1:0]),
    .word_o    (rdata_o),
    .valid_o   (rdata_valid_o)
  );
endmodule

// File: rtl/ebc_ctrl_chk.sv
module ebc_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              fetch_req_i,
  input logic              fetch_ack_o,
  input logic              wr_ack_o,
  input logic              rdata_valid_o,
  input logic [2*BYTE_W-1:0] ad_o,
  input logic              ad_oe_o,
  input logic              ale_o,
  input logic              ba0_o,
  input logic              ce_no,
  input logic              oe_no,
  input logic              wr_no
);
  a_r7_sleep_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (ce_no && oe_no && wr_no && !ale_o && !fetch_ack_o && !wr_ack_o));

  a_r8_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !ad_oe_o);

  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !wr_no));

  a_r5_dup_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (ad_oe_o && ad_o[2*BYTE_W-1:BYTE_W] == ad_o[BYTE_W-1:0]));

  a_r6_one_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_ack_o, wr_ack_o}));

  a_r6_fetch_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> !fetch_req_i);

  a_r2_ale_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (!ce_no && ad_oe_o && oe_no && wr_no));

  a_r4_valid_follows_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_no && ba0_o && !sleep_i) |=> rdata_valid_o);
endmodule

bind ebc_ctrl ebc_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_i       (sleep_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_ack_o   (fetch_ack_o),
  .wr_ack_o      (wr_ack_o),
  .rdata_valid_o (rdata_valid_o),
  .ad_o          (ad_o),
  .ad_oe_o       (ad_oe_o),
  .ale_o         (ale_o),
  .ba0_o         (ba0_o),
  .ce_no         (ce_no),
  .oe_no         (oe_no),
  .wr_no         (wr_no)
);

// File: tb/ebc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ebc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        f_req = 1'b0;
  logic [19:0] f_addr = '0;
  logic        f_ack;
  logic        w_req = 1'b0;
  logic [19:0] w_addr = '0;
  logic [7:0]  w_data = '0;
  logic        w_ack;
  logic [15:0] rdata;
  logic        rvalid;
  logic [3:0]  a_hi;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in;
  logic        ale, ba0, ce_n, oe_n, wr_n;

  int errs = 0;
  int checks = 0;
  logic [19:0] lat = '0;

  always #2.5 clk = ~clk;

  ebc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep),
    .fetch_req_i(f_req), .fetch_addr_i(f_addr), .fetch_ack_o(f_ack),
    .wr_req_i(w_req), .wr_addr_i(w_addr), .wr_data_i(w_data), .wr_ack_o(w_ack),
    .rdata_o(rdata), .rdata_valid_o(rvalid),
    .addr_hi_o(a_hi), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in),
    .ale_o(ale), .ba0_o(ba0), .ce_no(ce_n), .oe_no(oe_n), .wr_no(wr_n)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] b);
    return b[7:0] ^ b[15:8] ^ {b[19:16], b[19:16]} ^ 8'h5A;
  endfunction

  // external address latch and memory model
  always @(posedge clk) if (ale) lat <= {a_hi, ad_out};
  always_comb ad_in = !oe_n ? {8'h00, mem_byte({lat[19:1], ba0})} : 16'h0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nstep();
    @(negedge clk);
    #0.5;
  endtask

  task automatic chk_idle(input string req);
    chk(ce_n && oe_n && wr_n && !ale && !ad_oe, req,
        {ce_n, oe_n, wr_n, ale, ad_oe}, 5'b11100);
  endtask

  // fetch phases 1..4 and the valid pulse; entered right after posedge that starts ph1
  task automatic run_fetch_body(input logic [19:0] a);
    chk(ale && ad_oe && !ce_n && oe_n, "R2 ph1 strobes", {ale, ad_oe, ce_n, oe_n}, 4'b1101);
    chk(ad_out == {a[15:1], 1'b0} && a_hi == a[19:16], "R2 ph1 address",
        {a_hi, ad_out}, {a[19:16], a[15:1], 1'b0});
    for (int p = 2; p <= 4; p++) begin
      nstep();
      chk(!oe_n && !ce_n && !ad_oe && ba0 == (p == 4), "R3 read phase",
          {p[3:0], oe_n, ce_n, ad_oe, ba0}, {p[3:0], 3'b000, (p == 4)});
    end
  endtask

  task automatic do_fetch(input logic [19:0] a);
    logic [15:0] exp;
    exp = {mem_byte({a[19:1], 1'b1}), mem_byte({a[19:1], 1'b0})};
    nstep();
    f_req = 1'b1; f_addr = a;
    #0.5;
    chk(f_ack && !w_ack, "R6 fetch ack", {f_ack, w_ack}, 2'b10);
    nstep();
    f_req = 1'b0; f_addr = $urandom;
    #0.5;
    run_fetch_body(a);
    nstep();
    chk(rvalid && rdata == exp, "R4 word", {rvalid, rdata}, {1'b1, exp});
    nstep();
    chk(!rvalid, "R4 single pulse", rvalid, 0);
    chk_idle("R9 idle after fetch");
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d);
    nstep();
    w_req = 1'b1; w_addr = a; w_data = d;
    #0.5;
    chk(w_ack && !f_ack, "R6 write ack", {w_ack, f_ack}, 2'b10);
    nstep();
    w_req = 1'b0; w_data = $urandom;
    #0.5;
    chk(ale && ad_oe && ad_out == a[15:0] && a_hi == a[19:16] && ba0 == a[0] && wr_n,
        "R5 ph1", {ale, ad_oe, ba0, wr_n, a_hi, ad_out}, {3'b111, a[0], 1'b1, a});
    for (int p = 2; p <= 4; p++) begin
      nstep();
      chk(ad_oe && ad_out == {d, d} && ba0 == a[0] && oe_n && !ce_n && wr_n == (p != 3),
          "R5 data phase", {p[3:0], wr_n, ba0, ad_out}, {p[3:0], (p != 3), a[0], d, d});
    end
    nstep();
    chk_idle("R9 idle after write");
    chk(!rvalid, "R4 no valid on write", rvalid, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1F2E);
    // R1 reset
    repeat (3) nstep();
    chk_idle("R1 in reset");
    chk(!rvalid, "R1 valid low", rvalid, 0);
    nstep();
    rst_n = 1'b1;
    nstep();
    chk_idle("R1 after reset");
    repeat (3) begin nstep(); chk_idle("R9 no request"); end

    // directed corners
    do_fetch(20'hFFFFF);
    do_fetch(20'h00000);
    do_write(20'h12345, 8'hA5);
    do_write(20'hABCD0, 8'h00);

    // R6 priority: both requests present
    nstep();
    f_req = 1'b1; w_req = 1'b1; f_addr = 20'h2468A; w_addr = 20'h11111;
    #0.5;
    chk(f_ack && !w_ack, "R6 fetch priority", {f_ack, w_ack}, 2'b10);
    nstep();
    f_req = 1'b0;
    #0.5;
    chk(ale && ad_out == 16'h468A, "R6 fetch ran first", ad_out, 16'h468A);
    chk(!w_ack, "R6 no slot mid cycle", w_ack, 0);
    nstep(); nstep(); nstep();
    chk(w_ack, "R6 write taken in ph4", w_ack, 1);
    nstep();
    w_req = 1'b0;
    #0.5;
    chk(rvalid && ale && ba0 == 1'b1 && ad_out == 16'h1111, "R6 back-to-back write",
        {rvalid, ale, ad_out}, {2'b11, 16'h1111});
    repeat (4) nstep();
    chk_idle("R9 idle after pair");

    // R6 back-to-back fetches
    nstep();
    f_req = 1'b1; f_addr = 20'h30002;
    #0.5;
    chk(f_ack, "R6 first ack", f_ack, 1);
    nstep();
    f_addr = 20'h40005;
    #0.5;
    chk(!f_ack, "R6 no ack ph1", f_ack, 0);
    nstep(); nstep(); nstep();
    chk(f_ack, "R6 second ack ph4", f_ack, 1);
    nstep();
    f_req = 1'b0;
    #0.5;
    chk(rvalid && rdata == {mem_byte(20'h30003), mem_byte(20'h30002)}, "R4 first word",
        rdata, {mem_byte(20'h30003), mem_byte(20'h30002)});
    run_fetch_body(20'h40005);
    nstep();
    chk(rvalid && rdata == {mem_byte(20'h40005), mem_byte(20'h40004)}, "R4 second word",
        rdata, {mem_byte(20'h40005), mem_byte(20'h40004)});

    // R7 sleep blocks a start
    nstep();
    sleep = 1'b1; f_req = 1'b1; f_addr = 20'h55554;
    #0.5;
    chk(!f_ack && ce_n, "R7 no ack in sleep", {f_ack, ce_n}, 2'b01);
    nstep();
    chk_idle("R7 idle in sleep");
    sleep = 1'b0;
    #0.5;
    chk(f_ack, "R7 ack after wake", f_ack, 1);
    nstep();
    f_req = 1'b0;
    nstep();
    sleep = 1'b1;  // abort in ph2
    #0.5;
    chk_idle("R7 abort strobes");
    nstep();
    sleep = 1'b0;
    #0.5;
    chk_idle("R7 abandoned");
    for (int k = 0; k < 3; k++) begin
      nstep();
      chk(!rvalid && ce_n, "R7 no stray valid", {rvalid, ce_n}, 2'b01);
    end

    // random mix
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(1, 0) == 0) do_fetch($urandom);
      else do_write($urandom, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule